// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between the internal clock sources of a clock generator and its output pins. It gates four groups of clocks: a processor group, a peripheral-bus group, a memory group and a set of reference outputs. A free-running copy of the peripheral-bus clock is also gated. Each output has its own enable bit from the configuration registers. The processor, peripheral-bus and memory groups can also be halted by active-low stop pins, and a power-down pin stops everything and halts the oscillator.

A strap input gives four shared pins one of two roles. With the strap low they are stop and power-down inputs. With the strap high they become four more memory clock outputs, and all stop functions are treated as released. A stop or power-down request is sampled on a rising edge of the free-running peripheral clock. It is then applied at the next falling edge of each affected clock, so outputs always stop low and restart with a full high phase. After reset the outputs stay quiet until a settle counter, clocked by the reference clock, reaches its terminal count. A tristate bit releases the pad drivers.

Top module: `clkstop_ctrl`

## Requirements
- R1: After reset every clock output stays low until SETTLE_CYCLES reference-clock cycles have elapsed. From then on, outputs may run.
- R2: When strap_mode is 0, shr_pin_i is an input vector of active-low requests: bit 0 stops the processor group, bit 1 the peripheral group, bit 2 the memory group, and bit 3 powers down. In this mode shr_clk_o is held low and shr_drive_en is 0. When strap_mode is 1, shr_pin_i has no effect and shr_clk_o carries memory clocks.
- R3: An output toggles only when its enable bit is 1 and no stop request that applies to it is active.
- R4: The processor stop affects only cpu_clk_o. The peripheral stop affects only pci_clk_o. The memory stop affects only mem_clk_o and shr_clk_o. The stop requests never affect pcif_clk_o or ref_clk_o.
- R5: Power-down forces every output low, including pcif_clk_o and ref_clk_o, and drives osc_run to 0. Releasing power-down returns osc_run to 1.
- R6: A gated output is low whenever it is stopped. Its high pulses are never shorter than the high phase of its source clock.
- R7: A processor stop or restart sampled at a pcif_clk_i rising edge takes effect at the next falling edge of cpu_clk_i. When stopping, the last rising edge is at or before the sampling edge. When restarting, the first rising edge comes less than two cpu_clk_i periods after it.
- R8: A peripheral stop or restart sampled at a pcif_clk_i rising edge takes effect at the next falling edge of pci_clk_i. The first restarted rising edge comes no later than one pci_clk_i period after the sampling edge.
- R9: With tri_all at 1, drive_en and shr_drive_en are both 0. With tri_all at 0, drive_en is 1 and shr_drive_en equals strap_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; also clocks the settle counter |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_clk_i | input | 1 | Internal processor clock |
| pci_clk_i | input | 1 | Internal peripheral-bus clock |
| pcif_clk_i | input | 1 | Free-running peripheral clock; samples requests |
| mem_clk_i | input | 1 | Internal memory clock |
| strap_mode | input | 1 | 0: shared pins are requests, 1: shared pins are clocks |
| shr_pin_i | input | 4 | Shared pin input values (active-low requests) |
| cpu_en | input | CPU_N | Processor output enables |
| pci_en | input | PCI_N | Peripheral output enables |
| pcif_en | input | 1 | Free-running peripheral output enable |
| mem_en | input | MEM_N | Dedicated memory output enables |
| shr_en | input | 4 | Shared memory output enables |
| ref_en | input | REF_N | Reference output enables |
| tri_all | input | 1 | Release all pad drivers |
| cpu_clk_o | output | CPU_N | Gated processor clocks |
| pci_clk_o | output | PCI_N | Gated peripheral clocks |
| pcif_clk_o | output | 1 | Gated free-running peripheral clock |
| mem_clk_o | output | MEM_N | Gated dedicated memory clocks |
| shr_clk_o | output | 4 | Gated memory clocks on the shared pins |
| ref_clk_o | output | REF_N | Gated reference clocks |
| drive_en | output | 1 | Pad drive enable for the dedicated outputs |
| shr_drive_en | output | 1 | Pad drive enable for the shared pins |
| osc_run | output | 1 | Oscillator and VCO run request |

## Verification
The bench first drives the shared pins in both strap settings. This exposes a design that lets a stop request leak through while the pins are clocks, or one that drives clocks onto the pins while they are inputs. It then asserts each stop on its own to catch cross-coupling between groups, including any gating of the free-running and reference outputs. Power-down is combined with the other requests to check that it dominates. Timed stop and restart sequences, aligned to the sampling edge, catch an enable that switches on the wrong edge: such a design would emit a truncated high pulse or miss the latency bound. A pulse-width monitor records any runt that occurs anywhere in the run.

// File: rtl/clkstop_pkg.sv
// Shared definitions for the clock stop controller.
// Assumes the shared request pins use the bit order given by the STOP_* indices.
package clkstop_pkg;
    localparam int unsigned STOP_CPU = 0;
    localparam int unsigned STOP_PCI = 1;
    localparam int unsigned STOP_MEM = 2;
    localparam int unsigned STOP_PD  = 3;
    localparam int unsigned SHR_PINS = 4;

    // Active-high request set, bit order matching the shared pins.
    typedef struct packed {
        logic pd;
        logic mem;
        logic pci;
        logic cpu;
    } stop_req_t;
endpackage

// File: rtl/clkstop_settle.sv
// Power-up settle timer: counts reference cycles after reset and raises
// settled_o once SETTLE_CYCLES have elapsed. Assumes SETTLE_CYCLES >= 1.
module clkstop_settle #(
    parameter int unsigned SETTLE_CYCLES = 150000
) (
    input  logic clk_i,
    input  logic rst_n,
    output logic settled_o
);
    localparam int unsigned   CW    = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

    logic [CW-1:0] cnt_q;

    // Count up to the terminal value and hold there.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign settled_o = (cnt_q == LIMIT);

    AST_SETTLE_HOLD:  assert property (@(posedge clk_i) disable iff (!rst_n)
        settled_o |=> settled_o) else $error("settle flag dropped"); // R1
    AST_SETTLE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_n)
        !settled_o |=> (cnt_q == CW'($past(cnt_q) + 1'b1))) else $error("settle count skipped"); // R1
endmodule

// File: rtl/clkstop_req.sv
// Request sampler: captures the shared stop pins on the rising edge of the
// free-running peripheral clock. The pins are assumed to be synchronous to
// that clock. With the strap high all requests read as released.
module clkstop_req
    import clkstop_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_n,
    input  logic                strap_i,
    input  logic [SHR_PINS-1:0] pin_i,
    output stop_req_t           stop_o
);
    stop_req_t stop_q;

    // Sample active-low pins into active-high requests; masked when strapped as clocks.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            stop_q <= '0;
        end else if (strap_i) begin
            stop_q <= '0;
        end else begin
            stop_q <= stop_req_t'(~pin_i);
        end
    end

    assign stop_o = stop_q;

    AST_STRAP_MASK: assert property (@(posedge clk_i) disable iff (!rst_n)
        strap_i |=> (stop_q == '0)) else $error("request seen while strapped"); // R2
endmodule

// File: rtl/clkstop_gate.sv
// Glitch-free gate for one clock group. Each enable is retimed on the falling
// edge of the source clock and ANDed with it, so the output can change state
// only while the source is low. Assumes en_i is quasi-static or already
// synchronous to the falling edge.
module clkstop_gate #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] en_i,
    output logic [WIDTH-1:0] clk_o
);
    logic [WIDTH-1:0] en_q;

    // Retime the enables on the falling edge so they only move while clk_i is low.
    always_ff @(negedge clk_i) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_i;
        end
    end

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_and
            assign clk_o[g] = clk_i & en_q[g];
        end
    endgenerate

    // Check that an enable flip never lands during a high phase.
    always @(en_q) begin
        if (rst_n) begin
            AST_GATE_EDGE: assert (!clk_i) else $error("enable moved while clock high"); // R6
        end
    end
endmodule

// File: rtl/clkstop_ctrl.sv
// Clock stop controller top. Combines register enables, sampled stop
// requests, power-down and the settle timer into per-group enables, and
// gates each group with its own falling-edge gate. Assumes enables, strap
// and tristate are quasi-static relative to the group clocks.
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int unsigned CPU_N         = 3,
    parameter int unsigned PCI_N         = 5,
    parameter int unsigned MEM_N         = 9,
    parameter int unsigned REF_N         = 3,
    parameter int unsigned SETTLE_CYCLES = 150000
) (
    input  logic                clk_ref,
    input  logic                rst_n,
    input  logic                cpu_clk_i,
    input  logic                pci_clk_i,
    input  logic                pcif_clk_i,
    input  logic                mem_clk_i,
    input  logic                strap_mode,
    input  logic [SHR_PINS-1:0] shr_pin_i,
    input  logic [CPU_N-1:0]    cpu_en,
    input  logic [PCI_N-1:0]    pci_en,
    input  logic                pcif_en,
    input  logic [MEM_N-1:0]    mem_en,
    input  logic [SHR_PINS-1:0] shr_en,
    input  logic [REF_N-1:0]    ref_en,
    input  logic                tri_all,
    output logic [CPU_N-1:0]    cpu_clk_o,
    output logic [PCI_N-1:0]    pci_clk_o,
    output logic                pcif_clk_o,
    output logic [MEM_N-1:0]    mem_clk_o,
    output logic [SHR_PINS-1:0] shr_clk_o,
    output logic [REF_N-1:0]    ref_clk_o,
    output logic                drive_en,
    output logic                shr_drive_en,
    output logic                osc_run
);
    localparam int unsigned MEMW = MEM_N + SHR_PINS;

    stop_req_t              req;
    logic                   settled;
    logic                   run_ok;
    logic [CPU_N-1:0]       cpu_g;
    logic [PCI_N-1:0]       pci_g;
    logic [0:0]             pcif_g;
    logic [0:0]             pcif_o;
    logic [MEMW-1:0]        mem_g;
    logic [MEMW-1:0]        mem_o;
    logic [REF_N-1:0]       ref_g;

    clkstop_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) i_settle (
        .clk_i     (clk_ref),
        .rst_n     (rst_n),
        .settled_o (settled)
    );

    clkstop_req i_req (
        .clk_i   (pcif_clk_i),
        .rst_n   (rst_n),
        .strap_i (strap_mode),
        .pin_i   (shr_pin_i),
        .stop_o  (req)
    );

    // Build the per-group enables: register bit AND no applicable stop AND alive.
    always_comb begin
        run_ok = settled & ~req.pd;
        cpu_g  = cpu_en & {CPU_N{run_ok & ~req.cpu}};
        pci_g  = pci_en & {PCI_N{run_ok & ~req.pci}};
        pcif_g = pcif_en & run_ok;
        mem_g  = {shr_en & {SHR_PINS{strap_mode}}, mem_en} & {MEMW{run_ok & ~req.mem}};
        ref_g  = ref_en & {REF_N{run_ok}};
    end

    clkstop_gate #(.WIDTH(CPU_N)) i_gate_cpu (
        .clk_i (cpu_clk_i), .rst_n (rst_n), .en_i (cpu_g), .clk_o (cpu_clk_o)
    );
    clkstop_gate #(.WIDTH(PCI_N)) i_gate_pci (
        .clk_i (pci_clk_i), .rst_n (rst_n), .en_i (pci_g), .clk_o (pci_clk_o)
    );
    clkstop_gate #(.WIDTH(1)) i_gate_pcif (
        .clk_i (pcif_clk_i), .rst_n (rst_n), .en_i (pcif_g), .clk_o (pcif_o)
    );
    clkstop_gate #(.WIDTH(MEMW)) i_gate_mem (
        .clk_i (mem_clk_i), .rst_n (rst_n), .en_i (mem_g), .clk_o (mem_o)
    );
    clkstop_gate #(.WIDTH(REF_N)) i_gate_ref (
        .clk_i (clk_ref), .rst_n (rst_n), .en_i (ref_g), .clk_o (ref_clk_o)
    );

    assign pcif_clk_o   = pcif_o[0];
    assign mem_clk_o    = mem_o[MEM_N-1:0];
    assign shr_clk_o    = mem_o[MEMW-1:MEM_N];
    assign drive_en     = ~tri_all;
    assign shr_drive_en = ~tri_all & strap_mode;
    assign osc_run      = ~req.pd;

    AST_PCIF_HELD: assert property (@(negedge pcif_clk_i) disable iff (!rst_n)
        !settled |-> !pcif_clk_o) else $error("free clock ran before settle"); // R1
    AST_SHR_IDLE:  assert property (@(negedge mem_clk_i) disable iff (!rst_n)
        (!strap_mode && $past(!strap_mode)) |-> (shr_clk_o == '0)) else $error("shared pins driven as clocks"); // R2
    AST_PD_OSC:    assert property (@(posedge pcif_clk_i) disable iff (!rst_n)
        (!strap_mode && !shr_pin_i[STOP_PD]) |=> !osc_run) else $error("oscillator kept running"); // R5
endmodule

// File: tb/test_clkstop_ctrl.sv
module test_clkstop_ctrl;
    localparam int CPU_N = 3;
    localparam int PCI_N = 5;
    localparam int MEM_N = 9;
    localparam int REF_N = 3;
    localparam int TOT   = 25;
    localparam real CPU_PER = 10.0;
    localparam real PCI_PER = 30.0;
    localparam logic [TOT-1:0] ALL = 25'h1FFFFFF;
    localparam int NVEC = 9;
    // {strap, pins[3:0], enables[24:0], expected running mask[24:0]}
    // bit layout: [2:0] cpu, [7:3] pci, [8] pcif, [17:9] mem, [21:18] shared, [24:22] ref
    localparam logic [54:0] VECS [NVEC] = '{
        {1'b1, 4'b0000, 25'h1FFFFFF, 25'h1FFFFFF},
        {1'b0, 4'b1111, 25'h1FFFFFF, 25'h1C3FFFF},
        {1'b0, 4'b1110, 25'h1FFFFFF, 25'h1C3FFF8},
        {1'b0, 4'b1101, 25'h1FFFFFF, 25'h1C3FF07},
        {1'b0, 4'b1011, 25'h1FFFFFF, 25'h1C001FF},
        {1'b0, 4'b0111, 25'h1FFFFFF, 25'h0000000},
        {1'b0, 4'b0000, 25'h1FFFFFF, 25'h0000000},
        {1'b1, 4'b0000, 25'h0AAAAAA, 25'h0AAAAAA},
        {1'b0, 4'b1110, 25'h1555555, 25'h1415550}
    };

    logic clk_ref = 1'b0;
    logic pclk    = 1'b0;
    logic cclk    = 1'b0;
    always #10 clk_ref = ~clk_ref;
    always #15 pclk    = ~pclk;
    always #5  cclk    = ~cclk;

    logic           rst_n;
    logic           strap;
    logic [3:0]     pins;
    logic [TOT-1:0] en_all;
    logic           tri_all;
    logic [CPU_N-1:0] cpu_clk_o;
    logic [PCI_N-1:0] pci_clk_o;
    logic             pcif_clk_o;
    logic [MEM_N-1:0] mem_clk_o;
    logic [3:0]       shr_clk_o;
    logic [REF_N-1:0] ref_clk_o;
    logic drive_en, shr_drive_en, osc_run;

    clkstop_ctrl #(
        .CPU_N(CPU_N), .PCI_N(PCI_N), .MEM_N(MEM_N), .REF_N(REF_N), .SETTLE_CYCLES(64)
    ) i_clkstop_ctrl (
        .clk_ref(clk_ref), .rst_n(rst_n), .cpu_clk_i(cclk), .pci_clk_i(pclk),
        .pcif_clk_i(pclk), .mem_clk_i(cclk), .strap_mode(strap), .shr_pin_i(pins),
        .cpu_en(en_all[2:0]), .pci_en(en_all[7:3]), .pcif_en(en_all[8]),
        .mem_en(en_all[17:9]), .shr_en(en_all[21:18]), .ref_en(en_all[24:22]),
        .tri_all(tri_all), .cpu_clk_o(cpu_clk_o), .pci_clk_o(pci_clk_o),
        .pcif_clk_o(pcif_clk_o), .mem_clk_o(mem_clk_o), .shr_clk_o(shr_clk_o),
        .ref_clk_o(ref_clk_o), .drive_en(drive_en), .shr_drive_en(shr_drive_en),
        .osc_run(osc_run)
    );

    wire [TOT-1:0] all_o = {ref_clk_o, shr_clk_o, mem_clk_o, pcif_clk_o, pci_clk_o, cpu_clk_o};

    int nchk = 0;
    int nfail = 0;
    int nshort = 0;
    logic [TOT-1:0] seen;
    real rc_cpu = 0.0, rc_pci = 0.0, rc_mem = 0.0;
    real last_cpu = 0.0, last_pci = 0.0;
    real first_cpu = -1.0, first_pci = -1.0;

    // Accumulate which outputs went high during a window.
    always @(all_o) seen = seen | all_o;

    // Pulse-width and edge-time monitors (R6, R7, R8).
    always @(posedge cpu_clk_o[0]) begin
        rc_cpu = $realtime; last_cpu = $realtime;
        if (first_cpu < 0.0) first_cpu = $realtime;
    end
    always @(posedge pci_clk_o[0]) begin
        rc_pci = $realtime; last_pci = $realtime;
        if (first_pci < 0.0) first_pci = $realtime;
    end
    always @(posedge mem_clk_o[0]) rc_mem = $realtime;
    always @(negedge cpu_clk_o[0]) if (rst_n === 1'b1 && $realtime - rc_cpu < CPU_PER / 2.0 - 0.01) nshort++;
    always @(negedge pci_clk_o[0]) if (rst_n === 1'b1 && $realtime - rc_pci < PCI_PER / 2.0 - 0.01) nshort++;
    always @(negedge mem_clk_o[0]) if (rst_n === 1'b1 && $realtime - rc_mem < CPU_PER / 2.0 - 0.01) nshort++;

    task automatic check_bit(input logic ok, input string req, input string what,
                             input logic [TOT-1:0] got, input logic [TOT-1:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic window(input logic [TOT-1:0] exp, input string req, input string what);
        seen = '0;
        #600;
        check_bit(seen === exp, req, what, seen, exp);
    endtask

    task automatic apply(input logic s, input logic [3:0] p, input logic [TOT-1:0] e);
        @(posedge pclk);
        #1;
        strap = s; pins = p; en_all = e;
        #100;
    endtask

    initial begin
        #1_000_000;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; strap = 1'b1; pins = 4'hF; en_all = ALL; tri_all = 1'b0;
        repeat (10) @(posedge clk_ref);
        #3;
        // Reset state: all outputs low, oscillator running.
        check_bit(all_o === '0, "R1", "outputs during reset", all_o, '0);
        check_bit({24'd0, osc_run} === 25'd1, "R5", "osc_run during reset", {24'd0, osc_run}, 25'd1);
        @(posedge clk_ref);
        #1 rst_n = 1'b1;
        // R1: still within the settle count.
        window('0, "R1", "outputs before settle");
        #1000;

        // Stimulus table walk (R2, R3, R4, R5).
        for (int v = 0; v < NVEC; v++) begin
            logic [54:0] row;
            logic        exp_osc;
            row = VECS[v];
            apply(row[54], row[53:50], row[49:25]);
            window(row[24:0], "R3 R4", $sformatf("vector %0d running mask", v));
            exp_osc = !(row[54] == 1'b0 && row[53] == 1'b0);
            check_bit(osc_run === exp_osc, "R5", $sformatf("vector %0d osc_run", v),
                      {24'd0, osc_run}, {24'd0, exp_osc});
            check_bit(shr_drive_en === row[54], "R2", $sformatf("vector %0d shared drive", v),
                      {24'd0, shr_drive_en}, {24'd0, row[54]});
        end

        // R2: with strap high, asserted-looking pins are ignored.
        apply(1'b1, 4'b0000, ALL);
        window(ALL, "R2", "strap high ignores pins");

        // R7: processor stop timing.
        apply(1'b0, 4'b1111, ALL);
        begin
            real tp;
            @(posedge pclk); #1 pins[0] = 1'b0;
            @(posedge pclk); tp = $realtime;
            #62;
            check_bit(last_cpu <= tp + 0.1 && last_cpu >= tp - CPU_PER - 0.1 && cpu_clk_o === '0,
                      "R7", "cpu stop edge", {22'd0, cpu_clk_o}, '0);
            @(posedge pclk); #1 pins[0] = 1'b1;
            @(posedge pclk); tp = $realtime; first_cpu = -1.0;
            #62;
            check_bit(first_cpu > tp && first_cpu - tp < 2.0 * CPU_PER, "R7", "cpu restart latency",
                      25'($rtoi(first_cpu - tp)), 25'($rtoi(CPU_PER)));
        end

        // R8: peripheral stop timing.
        begin
            real tp;
            @(posedge pclk); #1 pins[1] = 1'b0;
            @(posedge pclk); tp = $realtime;
            #62;
            check_bit(last_pci <= tp + 0.1 && last_pci >= tp - PCI_PER - 0.1 && pci_clk_o === '0,
                      "R8", "pci stop edge", {20'd0, pci_clk_o}, '0);
            @(posedge pclk); #1 pins[1] = 1'b1;
            @(posedge pclk); tp = $realtime; first_pci = -1.0;
            #62;
            check_bit(first_pci > tp && first_pci - tp <= PCI_PER + 0.1, "R8", "pci restart latency",
                      25'($rtoi(first_pci - tp)), 25'($rtoi(PCI_PER)));
        end

        // R9: tristate control.
        apply(1'b1, 4'b1111, ALL);
        tri_all = 1'b1;
        #5;
        check_bit({drive_en, shr_drive_en} === 2'b00, "R9", "tristate drives",
                  {23'd0, drive_en, shr_drive_en}, '0);
        tri_all = 1'b0;
        #5;
        check_bit({drive_en, shr_drive_en} === 2'b11, "R9", "normal drives",
                  {23'd0, drive_en, shr_drive_en}, 25'd3);

        // R6: no runt pulse anywhere in the run.
        check_bit(nshort == 0, "R6", "short high pulses", 25'(nshort), '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule